// File: doc/BRIEF.md
# Doorbell Mailbox Register File

A two-sided mailbox that sits between a host and an embedded boot controller. The host places a command in a small bank of 64-bit command registers. Register 0 carries the header and the rest carry payload. The host then sets a bit in the host-to-controller doorbell. The controller reads the command, answers through a second bank of response registers, and signals back through the controller-to-host doorbell. Each doorbell drives a level interrupt to the side that receives it. The receiver acknowledges by clearing its doorbell bits, and the interrupt drops in the same cycle that the clear lands.

Each side has its own simple register bus: select, write strobe, address and write data, with read data returned one cycle later. Both sides see the same address map. Every doorbell appears at three addresses: a plain read/write alias, an AND alias that keeps only the bits written as one, and an OR alias that sets the bits written as one. An enable mask for each doorbell selects which of its bits raise the interrupt. The receiving side owns that mask. With the default `MSG_REGS` = 4, the map is as follows. Command registers are at 0..3 and response registers at 4..7. The host-to-controller doorbell is at 8 (read/write), 9 (AND) and 10 (OR). The controller-to-host doorbell is at 11 (read/write), 12 (AND) and 13 (OR). The host-to-controller mask is at 14 and the controller-to-host mask is at 15. Addresses 16..31 are unmapped.

Top module: `mbx_doorbell_mailbox`

## Requirements
- R1: Synchronous reset clears every command, response, doorbell and mask register to zero, and both interrupts are low after reset.
- R2: Command registers (offsets 0..MSG_REGS-1, offset 0 the header) are written only from the host port and read from either port. A controller write to them has no effect.
- R3: Response registers (offsets MSG_REGS..2*MSG_REGS-1) are written only from the controller port and read from either port. A host write to them has no effect.
- R4: A read returns data on the port's rdata in the cycle after the request. It returns the value held before any write in the same cycle, and rdata holds until the next read on that port.
- R5: A write to a doorbell's OR alias sets the written one-bits and leaves the other bits unchanged.
- R6: A write to a doorbell's AND alias keeps only the bits that are written as one and clears all the others.
- R7: A write to a doorbell's read/write alias replaces its value. A read of any of its three aliases returns the current value.
- R8: Each interrupt equals the OR of its doorbell bits that are enabled by the mask. The interrupt changes in the same cycle as the register update that causes it, so a clear deasserts it immediately. The host-to-controller interrupt goes to the controller port and the controller-to-host interrupt goes to the host port.
- R9: In the controller-to-host doorbell, bit 0 means message read, bit 1 response waiting, bit 2 passthrough request, bit 3 timer expiry and bit 4 controller back from reset. A mask that enables only bit 1 raises the host interrupt for a waiting response and not for the other events.
- R10: When both ports access the same doorbell in one cycle, the operations are applied in a fixed order. First a direct overwrite, where the controller's value wins if both ports overwrite. Then all AND masks. Then all OR bits.
- R11: The host-to-controller mask is writable only by the controller, and the controller-to-host mask only by the host. Unmapped addresses read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access request |
| host_wr | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, one cycle after request |
| host_irq | output | 1 | Controller-to-host doorbell interrupt |
| ctl_sel | input | 1 | Controller access request |
| ctl_wr | input | 1 | Controller access is a write |
| ctl_addr | input | ADDR_W | Controller register address |
| ctl_wdata | input | DATA_W | Controller write data |
| ctl_rdata | output | DATA_W | Controller read data, one cycle after request |
| ctl_irq | output | 1 | Host-to-controller doorbell interrupt |

## Verification
The bench builds the block with its defaults, DATA_W = 64 and MSG_REGS = 4. With these values the address map covers all 16 mapped offsets and leaves 16 unmapped ones. The bench can therefore sweep every mapped register after reset and also probe an address beyond the map. The full 64-bit width lets the AND and OR patterns touch high bits as well as the low event bits. The four-deep banks let the bench give the header and each payload slot a distinct value, so a wrong index shows up.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_CMD    = 3'd1,
        ACC_RSP    = 3'd2,
        ACC_DB_RW  = 3'd3,
        ACC_DB_AND = 3'd4,
        ACC_DB_OR  = 3'd5,
        ACC_MASK   = 3'd6,
        ACC_VOID   = 3'd7
    } acc_kind_e;

    typedef enum logic {
        DIR_H2C = 1'b0,
        DIR_C2H = 1'b1
    } dir_e;

    typedef enum logic {
        PORT_HOST = 1'b0,
        PORT_CTL  = 1'b1
    } port_e;

    typedef struct packed {
        logic      rd;
        logic      wr;
        acc_kind_e kind;
        dir_e      dir;
        logic [7:0] idx;
    } acc_t;

    localparam int DB_SLOTS = 8;

    function automatic int addr_width(input int nmsg);
        return $clog2(2 * nmsg + DB_SLOTS) + 1;
    endfunction

    function automatic acc_t decode(input logic [31:0] a, input int nmsg,
                                    input logic sel, input logic wr);
        acc_t r;
        logic [31:0] base;
        logic [31:0] off;
        base   = 32'(2 * nmsg);
        off    = a - base;
        r.rd   = sel & ~wr;
        r.wr   = sel & wr;
        r.kind = ACC_VOID;
        r.dir  = DIR_H2C;
        r.idx  = 8'd0;
        if (!sel) begin
            r.kind = ACC_NONE;
        end else if (a < 32'(nmsg)) begin
            r.kind = ACC_CMD;
            r.idx  = a[7:0];
        end else if (a < base) begin
            r.kind = ACC_RSP;
            r.idx  = 8'(a - 32'(nmsg));
        end else if (a < base + 32'(DB_SLOTS)) begin
            case (off[2:0])
                3'd0: begin r.kind = ACC_DB_RW;  r.dir = DIR_H2C; end
                3'd1: begin r.kind = ACC_DB_AND; r.dir = DIR_H2C; end
                3'd2: begin r.kind = ACC_DB_OR;  r.dir = DIR_H2C; end
                3'd3: begin r.kind = ACC_DB_RW;  r.dir = DIR_C2H; end
                3'd4: begin r.kind = ACC_DB_AND; r.dir = DIR_C2H; end
                3'd5: begin r.kind = ACC_DB_OR;  r.dir = DIR_C2H; end
                3'd6: begin r.kind = ACC_MASK;   r.dir = DIR_H2C; end
                default: begin r.kind = ACC_MASK; r.dir = DIR_C2H; end
            endcase
        end
        return r;
    endfunction

    // Write permission: each side owns its outbound data and its inbound mask
    function automatic logic may_write(input port_e p, input acc_t a);
        logic ok;
        case (a.kind)
            ACC_CMD:    ok = (p == PORT_HOST);
            ACC_RSP:    ok = (p == PORT_CTL);
            ACC_MASK:   ok = (a.dir == DIR_H2C) ? (p == PORT_CTL) : (p == PORT_HOST);
            ACC_DB_RW, ACC_DB_AND, ACC_DB_OR: ok = 1'b1;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int    MSG_REGS = 4,
    parameter int    ADDR_W   = 5,
    parameter port_e PORT     = PORT_HOST
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);

    acc_t raw;

    always_comb begin
        raw    = decode(32'(addr), MSG_REGS, sel, wr);
        acc    = raw;
        acc.wr = raw.wr & may_write(PORT, raw);
    end

endmodule

// File: rtl/mbx_msg_bank.sv
module mbx_msg_bank #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DEPTH-1:0][DATA_W-1:0]  regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (we) begin
            regs[idx] <= wdata;
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs)); // R2, R3

    AST_BANK_STORE: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(idx)] == $past(wdata)); // R2, R3

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
    parameter int DATA_W = 64,
    parameter int NPORT  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0]             rw_en,
    input  logic [NPORT-1:0]             and_en,
    input  logic [NPORT-1:0]             or_en,
    input  logic [NPORT-1:0]             mask_we,
    input  logic [NPORT-1:0][DATA_W-1:0] wdata,
    output logic [DATA_W-1:0]            db,
    output logic [DATA_W-1:0]            mask,
    output logic                         irq
);

    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] setb;
    logic [DATA_W-1:0] db_nxt;
    logic [DATA_W-1:0] mask_nxt;

    // Overwrite first (higher port index wins), then AND, then OR
    always_comb begin
        base     = db;
        keep     = '1;
        setb     = '0;
        mask_nxt = mask;
        for (int p = 0; p < NPORT; p++) begin
            if (rw_en[p])   base     = wdata[p];
            if (and_en[p])  keep     = keep & wdata[p];
            if (or_en[p])   setb     = setb | wdata[p];
            if (mask_we[p]) mask_nxt = wdata[p];
        end
        db_nxt = (base & keep) | setb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            db   <= '0;
            mask <= '0;
        end else begin
            db   <= db_nxt;
            mask <= mask_nxt;
        end
    end

    assign irq = |(db & mask);

    AST_OR_SETS: assert property (@(posedge clk) disable iff (rst)
        (or_en == NPORT'(1) && rw_en == '0 && and_en == '0)
        |=> (db & $past(wdata[0])) == $past(wdata[0])); // R5

    AST_AND_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (and_en == NPORT'(1) && rw_en == '0 && or_en == '0)
        |=> db == ($past(db) & $past(wdata[0]))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rw_en == '0 && and_en == '0 && or_en == '0) |=> $stable(db)); // R7

    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (!irq && rw_en == '0 && or_en == '0 && mask_we == '0) |=> !irq); // R8

endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port
    import mbx_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int MSG_REGS = 4,
    localparam int IDX_W   = (MSG_REGS > 1) ? $clog2(MSG_REGS) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  acc_t                            acc,
    input  logic [MSG_REGS-1:0][DATA_W-1:0] cmd,
    input  logic [MSG_REGS-1:0][DATA_W-1:0] rsp,
    input  logic [1:0][DATA_W-1:0]          db,
    input  logic [1:0][DATA_W-1:0]          mask,
    output logic [DATA_W-1:0]               rdata
);

    logic [DATA_W-1:0] sel_val;

    always_comb begin
        case (acc.kind)
            ACC_CMD:                          sel_val = cmd[acc.idx[IDX_W-1:0]];
            ACC_RSP:                          sel_val = rsp[acc.idx[IDX_W-1:0]];
            ACC_DB_RW, ACC_DB_AND, ACC_DB_OR: sel_val = db[acc.dir];
            ACC_MASK:                         sel_val = mask[acc.dir];
            default:                          sel_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (acc.rd) begin
            rdata <= sel_val;
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !acc.rd |=> $stable(rdata)); // R4

    AST_VOID_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.kind == ACC_VOID) |=> rdata == '0); // R11

endmodule

// File: rtl/mbx_doorbell_mailbox.sv
module mbx_doorbell_mailbox
    import mbx_pkg::*;
#(
    parameter int  DATA_W   = 64,
    parameter int  MSG_REGS = 4,
    localparam int ADDR_W   = $clog2(2 * MSG_REGS + DB_SLOTS) + 1,
    localparam int IDX_W    = (MSG_REGS > 1) ? $clog2(MSG_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq,
    input  logic              ctl_sel,
    input  logic              ctl_wr,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              ctl_irq
);

    logic [1:0]              p_sel;
    logic [1:0]              p_wr;
    logic [1:0][ADDR_W-1:0]  p_addr;
    logic [1:0][DATA_W-1:0]  p_wdata;
    logic [1:0][DATA_W-1:0]  p_rdata;
    acc_t                    p_acc [2];

    logic [MSG_REGS-1:0][DATA_W-1:0] cmd_regs;
    logic [MSG_REGS-1:0][DATA_W-1:0] rsp_regs;
    logic [1:0][DATA_W-1:0]          db_val;
    logic [1:0][DATA_W-1:0]          mask_val;
    logic [1:0]                      db_irq;

    assign p_sel   = {ctl_sel, host_sel};
    assign p_wr    = {ctl_wr, host_wr};
    assign p_addr  = {ctl_addr, host_addr};
    assign p_wdata = {ctl_wdata, host_wdata};

    genvar gp, gd;
    generate
        for (gp = 0; gp < 2; gp++) begin : g_port
            mbx_port_decode #(
                .MSG_REGS (MSG_REGS),
                .ADDR_W   (ADDR_W),
                .PORT     (port_e'(gp))
            ) i_dec (
                .sel  (p_sel[gp]),
                .wr   (p_wr[gp]),
                .addr (p_addr[gp]),
                .acc  (p_acc[gp])
            );

            mbx_read_port #(
                .DATA_W   (DATA_W),
                .MSG_REGS (MSG_REGS)
            ) i_rd (
                .clk   (clk),
                .rst   (rst),
                .acc   (p_acc[gp]),
                .cmd   (cmd_regs),
                .rsp   (rsp_regs),
                .db    (db_val),
                .mask  (mask_val),
                .rdata (p_rdata[gp])
            );
        end

        for (gd = 0; gd < 2; gd++) begin : g_bell
            logic [1:0] rw_en, and_en, or_en, mask_we;
            always_comb begin
                for (int p = 0; p < 2; p++) begin
                    rw_en[p]   = p_acc[p].wr && p_acc[p].kind == ACC_DB_RW  && p_acc[p].dir == dir_e'(gd);
                    and_en[p]  = p_acc[p].wr && p_acc[p].kind == ACC_DB_AND && p_acc[p].dir == dir_e'(gd);
                    or_en[p]   = p_acc[p].wr && p_acc[p].kind == ACC_DB_OR  && p_acc[p].dir == dir_e'(gd);
                    mask_we[p] = p_acc[p].wr && p_acc[p].kind == ACC_MASK   && p_acc[p].dir == dir_e'(gd);
                end
            end

            mbx_doorbell #(
                .DATA_W (DATA_W),
                .NPORT  (2)
            ) i_db (
                .clk     (clk),
                .rst     (rst),
                .rw_en   (rw_en),
                .and_en  (and_en),
                .or_en   (or_en),
                .mask_we (mask_we),
                .wdata   (p_wdata),
                .db      (db_val[gd]),
                .mask    (mask_val[gd]),
                .irq     (db_irq[gd])
            );
        end
    endgenerate

    mbx_msg_bank #(
        .DATA_W (DATA_W),
        .DEPTH  (MSG_REGS)
    ) i_cmd_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (p_acc[PORT_HOST].wr && p_acc[PORT_HOST].kind == ACC_CMD),
        .idx   (p_acc[PORT_HOST].idx[IDX_W-1:0]),
        .wdata (host_wdata),
        .regs  (cmd_regs)
    );

    mbx_msg_bank #(
        .DATA_W (DATA_W),
        .DEPTH  (MSG_REGS)
    ) i_rsp_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (p_acc[PORT_CTL].wr && p_acc[PORT_CTL].kind == ACC_RSP),
        .idx   (p_acc[PORT_CTL].idx[IDX_W-1:0]),
        .wdata (ctl_wdata),
        .regs  (rsp_regs)
    );

    assign host_rdata = p_rdata[PORT_HOST];
    assign ctl_rdata  = p_rdata[PORT_CTL];
    assign ctl_irq    = db_irq[DIR_H2C];
    assign host_irq   = db_irq[DIR_C2H];

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!host_irq && !ctl_irq && host_rdata == '0 && ctl_rdata == '0)); // R1

    AST_CTL_NO_CMD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!(host_sel && host_wr) && ctl_sel && ctl_wr && ctl_addr < ADDR_W'(MSG_REGS))
        |=> $stable(cmd_regs)); // R2

    AST_HOST_NO_RSP_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!(ctl_sel && ctl_wr) && host_sel && host_wr)
        |=> $stable(rsp_regs)); // R3

endmodule

// File: tb/test_mbx_doorbell_mailbox.sv
`timescale 1ns/1ps
module test_mbx_doorbell_mailbox;

    localparam int DW = 64;
    localparam int N  = 4;
    localparam int AW = $clog2(2 * N + 8) + 1;

    localparam logic [AW-1:0] A_CMD0 = 0, A_RSP0 = AW'(N);
    localparam logic [AW-1:0] A_H2C_RW = AW'(2*N+0), A_H2C_AND = AW'(2*N+1), A_H2C_OR = AW'(2*N+2);
    localparam logic [AW-1:0] A_C2H_RW = AW'(2*N+3), A_C2H_AND = AW'(2*N+4), A_C2H_OR = AW'(2*N+5);
    localparam logic [AW-1:0] A_H2C_MASK = AW'(2*N+6), A_C2H_MASK = AW'(2*N+7);
    localparam logic [AW-1:0] A_VOID = AW'(2*N+12);

    localparam logic [DW-1:0] EV_ACK = 64'h1, EV_RESP = 64'h2, EV_PASS = 64'h4,
                              EV_TIMER = 64'h8, EV_BACK = 64'h10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_sel = 0, host_wr = 0, ctl_sel = 0, ctl_wr = 0;
    logic [AW-1:0] host_addr = '0, ctl_addr = '0;
    logic [DW-1:0] host_wdata = '0, ctl_wdata = '0;
    logic [DW-1:0] host_rdata, ctl_rdata;
    logic host_irq, ctl_irq;

    always #2.5 clk = ~clk;

    mbx_doorbell_mailbox #(.DATA_W(DW), .MSG_REGS(N)) i_mbx_doorbell_mailbox (
        .clk(clk), .rst(rst),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .ctl_sel(ctl_sel), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_irq(ctl_irq)
    );

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    typedef struct {
        bit            port;
        logic [DW-1:0] exp;
        string         tag;
        int            due;
    } item_t;
    item_t sb_q[$];
    item_t cur;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: compares read data in the cycle the scoreboard item falls due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            cur = sb_q.pop_front();
            check(cur.tag, cur.port ? ctl_rdata : host_rdata, cur.exp);
        end
    end

    task automatic drive(input bit hs, input bit hw, input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                         input bit cs, input bit cw, input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                         input bit hchk, input logic [DW-1:0] hexp,
                         input bit cchk, input logic [DW-1:0] cexp, input string tag);
        item_t it;
        @(negedge clk);
        if (hchk) begin
            it.port = 1'b0; it.exp = hexp; it.tag = {tag, " host"}; it.due = cyc + 1;
            sb_q.push_back(it);
        end
        if (cchk) begin
            it.port = 1'b1; it.exp = cexp; it.tag = {tag, " ctl"}; it.due = cyc + 1;
            sb_q.push_back(it);
        end
        host_sel = hs; host_wr = hw; host_addr = ha; host_wdata = hd;
        ctl_sel = cs;  ctl_wr = cw;  ctl_addr = ca;  ctl_wdata = cd;
        @(negedge clk);
        host_sel = 0; host_wr = 0; ctl_sel = 0; ctl_wr = 0;
    endtask

    task automatic hwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        drive(1, 1, a, d, 0, 0, '0, '0, 0, '0, 0, '0, "");
    endtask
    task automatic cwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        drive(0, 0, '0, '0, 1, 1, a, d, 0, '0, 0, '0, "");
    endtask
    task automatic hrd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        drive(1, 0, a, '0, 0, 0, '0, '0, 1, e, 0, '0, tag);
    endtask
    task automatic crd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        drive(0, 0, '0, '0, 1, 0, a, '0, 0, '0, 1, e, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: everything reads zero after reset, interrupts low
        check("R1 host_irq", {63'd0, host_irq}, '0);
        check("R1 ctl_irq", {63'd0, ctl_irq}, '0);
        for (int a = 0; a < 2 * N + 8; a++) hrd(AW'(a), '0, "R1 reset value");

        // R2: host writes command header and payload, controller reads
        for (int i = 0; i < N; i++) hwr(A_CMD0 + AW'(i), 64'hC0DE_0000_0000_0000 | 64'(i * 17 + 3));
        for (int i = 0; i < N; i++) crd(A_CMD0 + AW'(i), 64'hC0DE_0000_0000_0000 | 64'(i * 17 + 3), "R2 cmd readback");
        cwr(A_CMD0 + 1, 64'hBAD0);
        hrd(A_CMD0 + 1, 64'hC0DE_0000_0000_0014, "R2 ctl write ignored");

        // R3: controller writes responses, host reads
        for (int i = 0; i < N; i++) cwr(A_RSP0 + AW'(i), 64'h5A5A_0000_0000_0100 + 64'(i));
        for (int i = 0; i < N; i++) hrd(A_RSP0 + AW'(i), 64'h5A5A_0000_0000_0100 + 64'(i), "R3 rsp readback");
        hwr(A_RSP0 + 2, 64'hBAD1);
        crd(A_RSP0 + 2, 64'h5A5A_0000_0000_0102, "R3 host write ignored");

        // R4: rdata holds after a read while other traffic runs
        hrd(A_CMD0, 64'hC0DE_0000_0000_0003, "R4 read header");
        hwr(A_CMD0, 64'h1234);
        check("R4 rdata hold", host_rdata, 64'hC0DE_0000_0000_0003);

        // R5/R8/R11: host rings controller doorbell
        hwr(A_H2C_OR, 64'h1);
        check("R8 no irq while masked", {63'd0, ctl_irq}, '0);
        cwr(A_H2C_MASK, 64'h1);
        check("R8 ctl_irq on enable", {63'd0, ctl_irq}, 64'd1);
        hwr(A_H2C_MASK, 64'hFF);
        crd(A_H2C_MASK, 64'h1, "R11 host cannot write h2c mask");
        hwr(A_H2C_OR, 64'h8000_0000_0000_0000);
        crd(A_H2C_RW, 64'h8000_0000_0000_0001, "R5 OR sets bits");

        // R6/R8: controller clears bit 0 via AND alias
        cwr(A_H2C_AND, ~64'h1);
        check("R8 ctl_irq drops on clear", {63'd0, ctl_irq}, '0);
        hrd(A_H2C_AND, 64'h8000_0000_0000_0000, "R6 AND keeps ones");

        // R9: controller signals events; only response-waiting enabled
        hwr(A_C2H_MASK, EV_RESP);
        cwr(A_C2H_OR, EV_ACK | EV_PASS | EV_TIMER | EV_BACK);
        check("R9 other events masked", {63'd0, host_irq}, '0);
        cwr(A_C2H_OR, EV_RESP);
        check("R9 response irq", {63'd0, host_irq}, 64'd1);
        hwr(A_C2H_AND, ~EV_RESP);
        check("R9 response irq cleared", {63'd0, host_irq}, '0);
        crd(A_C2H_OR, EV_ACK | EV_PASS | EV_TIMER | EV_BACK, "R7 read via OR alias");
        cwr(A_C2H_MASK, 64'hFFFF);
        hrd(A_C2H_MASK, EV_RESP, "R11 ctl cannot write c2h mask");

        // R7: direct overwrite
        hwr(A_C2H_RW, 64'hA5);
        crd(A_C2H_RW, 64'hA5, "R7 overwrite");
        check("R8 irq after overwrite (bit1 clear)", {63'd0, host_irq}, '0);

        // R10: simultaneous access ordering
        drive(1, 1, A_C2H_RW, 64'h0F, 1, 1, A_C2H_RW, 64'hF0, 0, '0, 0, '0, "");
        hrd(A_C2H_RW, 64'hF0, "R10 ctl overwrite wins");
        drive(1, 1, A_C2H_AND, 64'h30, 1, 1, A_C2H_OR, 64'h01, 0, '0, 0, '0, "");
        hrd(A_C2H_RW, 64'h31, "R10 AND before OR");
        drive(1, 1, A_C2H_AND, 64'h21, 1, 1, A_C2H_AND, 64'h31, 0, '0, 0, '0, "");
        crd(A_C2H_RW, 64'h21, "R10 both ANDs");
        drive(1, 1, A_C2H_RW, 64'h400, 1, 1, A_C2H_OR, 64'h02, 0, '0, 0, '0, "");
        hrd(A_C2H_RW, 64'h402, "R10 overwrite then OR");
        check("R8 irq from concurrent OR", {63'd0, host_irq}, 64'd1);

        // R4: read sees the value before a same-cycle write
        drive(1, 0, A_C2H_RW, '0, 1, 1, A_C2H_OR, 64'h100, 1, 64'h402, 0, '0, "R4 pre-write value");
        hrd(A_C2H_RW, 64'h502, "R4 post-write value");

        // R11: unmapped address
        hwr(A_VOID, 64'hDEAD_BEEF);
        cwr(A_VOID, 64'hFEED);
        hrd(A_VOID, '0, "R11 unmapped host");
        crd(A_VOID, '0, "R11 unmapped ctl");
        crd(A_C2H_RW, 64'h502, "R11 unmapped write no effect");

        // R1: reset in mid-run clears everything again
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R1 irqs after second reset", {62'd0, host_irq, ctl_irq}, '0);
        hrd(A_CMD0, '0, "R1 cmd cleared");
        crd(A_RSP0, '0, "R1 rsp cleared");
        hrd(A_H2C_RW, '0, "R1 h2c cleared");
        crd(A_C2H_MASK, '0, "R1 mask cleared");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule